// File: doc/BRIEF.md
# Opcode-Selected Eight-Bit Lookup ALU

This block is the arithmetic and logic unit of a small accumulator machine. It takes two unsigned operands, the accumulator value A and a second operand B, and a 4-bit function code. From these it forms an 8-bit result through a fixed sixteen-entry function table. Some codes produce a data value (logic, shifts, add, subtract, multiply, move). Others produce a true/false answer, which is placed in bit 0 of the result with the upper bits zero.

The result is combinational. A load strobe copies it into a holding register, and the machine writes that register back into the accumulator. A separate flag output carries the true/false answer of the five test functions, so that conditional branches can use it without decoding the result. All arithmetic is unsigned, and every value is kept to the operand width.

Top module: `opsel_alu`

## Requirements
- R1: Code 0 gives A AND B, code 1 gives A OR B, and code 2 gives the bitwise complement of A.
- R2: Code 3 gives A+1 and code 4 gives A-1, both modulo 256 (255+1=0, 0-1=255).
- R3: Code 5 shifts A right by one bit and code 15 shifts A left by one bit. In both cases the vacated bit is filled with 0.
- R4: Code 6 gives A+B and code 7 gives A-B, both unsigned and modulo 256.
- R5: Codes 8, 9 and 10 give 1 when A>B, A=B and A<B respectively, under unsigned comparison, and 0 otherwise. The answer sits in result bit 0, and bits 7..1 are zero.
- R6: Code 11 passes B to the result. Code 12 gives the low 8 bits of the 16-bit product A*B.
- R7: Code 13 gives 1 when A is zero, whatever the value of B. Code 14 gives 1 when the full sum A+B is greater than 255. Both place the answer in bit 0, with bits 7..1 zero.
- R8: flag_o equals result bit 0 for codes 8, 9, 10, 13 and 14, and is 0 for every other code.
- R9: hold_o resets to 0. When load_i is high at a rising clock edge, hold_o takes the result. When load_i is low, hold_o keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 8 | Accumulator operand A |
| b_i | input | 8 | Second operand B |
| func_i | input | 4 | Function code |
| load_i | input | 1 | Capture the result into the holding register |
| result_o | output | 8 | Combinational result |
| flag_o | output | 1 | Test answer for the flag functions, otherwise 0 |
| hold_o | output | 8 | Holding register, written back to the accumulator |

## Verification
The bench runs every code against operand pairs chosen to sit on the edges of the table.

- Wrap cases: 255+1, 0-1, 255+255 and 0-1 through subtract. A design that carried a ninth bit or saturated would return the wrong low byte.
- Shifts of 0x80, 0x01 and 0x55. A rotate instead of a shift would bring a 1 back into the vacated bit.
- Equal, adjacent and extreme operands for the comparisons. An off-by-one or a signed comparison would invert the answer, for example treating 0x80 as less than 0x7F.
- Zero test with a nonzero B, and carry test at exactly 255 and 256. These expose a zero test that also looks at B, and a carry test that uses >= instead of >.
- Loads interleaved with idle cycles, to show whether the holding register drifts when the strobe is low.

// File: rtl/opsel_alu_pkg.sv
package opsel_alu_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned FUNC_W = 4;

  typedef enum logic [FUNC_W-1:0] {
    OP_AND   = 4'd0,
    OP_OR    = 4'd1,
    OP_NOT   = 4'd2,
    OP_INC   = 4'd3,
    OP_DEC   = 4'd4,
    OP_SHR   = 4'd5,
    OP_ADD   = 4'd6,
    OP_SUB   = 4'd7,
    OP_GT    = 4'd8,
    OP_EQ    = 4'd9,
    OP_LT    = 4'd10,
    OP_MOVB  = 4'd11,
    OP_MUL   = 4'd12,
    OP_ZERO  = 4'd13,
    OP_CARRY = 4'd14,
    OP_SHL   = 4'd15
  } op_e;

  function automatic logic is_test_op(op_e op);
    return (op == OP_GT) || (op == OP_EQ) || (op == OP_LT) ||
           (op == OP_ZERO) || (op == OP_CARRY);
  endfunction
endpackage

// File: rtl/opsel_logic.sv
module opsel_logic #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] and_o,
  output logic [W-1:0] or_o,
  output logic [W-1:0] not_o,
  output logic [W-1:0] shr_o,
  output logic [W-1:0] shl_o,
  output logic [W-1:0] movb_o
);
  assign and_o  = a_i & b_i;
  assign or_o   = a_i | b_i;
  assign not_o  = ~a_i;
  assign shr_o  = {1'b0, a_i[W-1:1]};
  assign shl_o  = {a_i[W-2:0], 1'b0};
  assign movb_o = b_i;
endmodule

// File: rtl/opsel_arith.sv
module opsel_arith #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] inc_o,
  output logic [W-1:0] dec_o,
  output logic [W-1:0] add_o,
  output logic [W-1:0] sub_o,
  output logic [W-1:0] mul_o,
  output logic         carry_o
);
  localparam int unsigned PW = 2 * W;

  logic [W:0]    sum_full;
  logic [PW-1:0] prod_full;

  assign sum_full  = {1'b0, a_i} + {1'b0, b_i};
  assign prod_full = PW'(a_i) * PW'(b_i);

  assign inc_o   = a_i + W'(1);
  assign dec_o   = a_i - W'(1);
  assign add_o   = sum_full[W-1:0];
  assign sub_o   = a_i - b_i;
  assign mul_o   = prod_full[W-1:0];
  assign carry_o = sum_full[W];
endmodule

// File: rtl/opsel_cmp.sv
module opsel_cmp #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         gt_o,
  output logic         eq_o,
  output logic         lt_o,
  output logic         zero_o
);
  assign gt_o   = a_i > b_i;
  assign eq_o   = a_i == b_i;
  assign lt_o   = a_i < b_i;
  assign zero_o = ~|a_i;
endmodule

// File: rtl/opsel_alu.sv
module opsel_alu
  import opsel_alu_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [3:0]   func_i,
  input  logic         load_i,
  output logic [W-1:0] result_o,
  output logic         flag_o,
  output logic [W-1:0] hold_o
);
  logic [W-1:0] and_v, or_v, not_v, shr_v, shl_v, movb_v;
  logic [W-1:0] inc_v, dec_v, add_v, sub_v, mul_v;
  logic         carry_v, gt_v, eq_v, lt_v, zero_v;
  logic         test_bit;
  op_e          op;

  assign op = op_e'(func_i);

  opsel_logic #(.W(W)) u_logic (
    .a_i(a_i), .b_i(b_i),
    .and_o(and_v), .or_o(or_v), .not_o(not_v),
    .shr_o(shr_v), .shl_o(shl_v), .movb_o(movb_v)
  );

  opsel_arith #(.W(W)) u_arith (
    .a_i(a_i), .b_i(b_i),
    .inc_o(inc_v), .dec_o(dec_v), .add_o(add_v),
    .sub_o(sub_v), .mul_o(mul_v), .carry_o(carry_v)
  );

  opsel_cmp #(.W(W)) u_cmp (
    .a_i(a_i), .b_i(b_i),
    .gt_o(gt_v), .eq_o(eq_v), .lt_o(lt_v), .zero_o(zero_v)
  );

  always_comb begin
    test_bit = 1'b0;
    unique case (op)
      OP_GT:    test_bit = gt_v;
      OP_EQ:    test_bit = eq_v;
      OP_LT:    test_bit = lt_v;
      OP_ZERO:  test_bit = zero_v;
      OP_CARRY: test_bit = carry_v;
      default:  test_bit = 1'b0;
    endcase
  end

  always_comb begin
    unique case (op)
      OP_AND:  result_o = and_v;
      OP_OR:   result_o = or_v;
      OP_NOT:  result_o = not_v;
      OP_INC:  result_o = inc_v;
      OP_DEC:  result_o = dec_v;
      OP_SHR:  result_o = shr_v;
      OP_ADD:  result_o = add_v;
      OP_SUB:  result_o = sub_v;
      OP_MOVB: result_o = movb_v;
      OP_MUL:  result_o = mul_v;
      OP_SHL:  result_o = shl_v;
      default: result_o = {{(W-1){1'b0}}, test_bit};
    endcase
  end

  assign flag_o = is_test_op(op) & test_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hold_o <= '0;
    else if (load_i) hold_o <= result_o;
  end

  assert_cmp_exclusive_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({gt_v, eq_v, lt_v}) == 1);

  assert_test_upper_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_test_op(op) |-> (result_o[W-1:1] == '0));

  assert_flag_matches_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_test_op(op) |-> (flag_o == result_o[0]));

  assert_flag_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_test_op(op) |-> !flag_o);

  assert_zero_ignores_b_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_ZERO) |-> (result_o[0] == (a_i == '0)));

  assert_hold_capture_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (hold_o == $past(result_o)));

  assert_hold_keep_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(hold_o));
endmodule

// File: tb/opsel_alu_bench.sv
`timescale 1ns/1ps
module opsel_alu_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] a = '0, b = '0;
  logic [3:0] func = '0;
  logic       load = 1'b0;
  logic [7:0] result, hold;
  logic       flag;

  int checks = 0;
  int errors = 0;
  logic [7:0] hold_exp = '0;
  logic       done = 1'b0;

  // item: {load, func, result, flag}
  logic [13:0] sb_q[$];

  always #4 clk = ~clk;

  opsel_alu u_opsel_alu (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(b), .func_i(func),
    .load_i(load), .result_o(result), .flag_o(flag), .hold_o(hold)
  );

  function automatic string req_of(logic [3:0] f);
    case (f)
      4'd0, 4'd1, 4'd2: return "R1";
      4'd3, 4'd4:       return "R2";
      4'd5, 4'd15:      return "R3";
      4'd6, 4'd7:       return "R4";
      4'd8, 4'd9, 4'd10: return "R5";
      4'd11, 4'd12:     return "R6";
      default:          return "R7";
    endcase
  endfunction

  function automatic logic [8:0] model(logic [3:0] f, logic [7:0] x, logic [7:0] y);
    int s;
    int p;
    logic t;
    s = int'(x) + int'(y);
    p = int'(x) * int'(y);
    t = 1'b0;
    case (f)
      4'd0:  return {x & y, 1'b0};
      4'd1:  return {x | y, 1'b0};
      4'd2:  return {~x, 1'b0};
      4'd3:  return {8'((int'(x) + 1) % 256), 1'b0};
      4'd4:  return {8'((int'(x) + 255) % 256), 1'b0};
      4'd5:  return {8'(x / 2), 1'b0};
      4'd6:  return {8'(s % 256), 1'b0};
      4'd7:  return {8'((int'(x) - int'(y) + 256) % 256), 1'b0};
      4'd11: return {y, 1'b0};
      4'd12: return {8'(p % 256), 1'b0};
      4'd15: return {8'((int'(x) * 2) % 256), 1'b0};
      4'd8:  t = (x > y);
      4'd9:  t = (x == y);
      4'd10: t = (x < y);
      4'd13: t = (x == 8'd0);
      default: t = (s > 255);
    endcase
    return {7'd0, t, t};
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(logic [3:0] f, logic [7:0] x, logic [7:0] y, logic ld);
    logic [8:0] m;
    @(negedge clk);
    func = f; a = x; b = y; load = ld;
    m = model(f, x, y);
    sb_q.push_back({ld, f, m});
  endtask

  // monitor: compares just after the edge, inputs stable since previous negedge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        logic [13:0] it;
        it = sb_q.pop_front();
        check(req_of(it[12:9]), "result", int'(result), int'(it[8:1]));
        check("R8", "flag", int'(flag), int'(it[0]));
        if (it[13]) hold_exp = it[8:1];
        check("R9", "hold", int'(hold), int'(hold_exp));
      end
    end
  end

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  localparam int NP = 12;
  logic [7:0] pa [NP] = '{8'h00, 8'hFF, 8'hFF, 8'h00, 8'h80, 8'h55, 8'h03, 8'hC8, 8'h10, 8'h01, 8'h7F, 8'h00};
  logic [7:0] pb [NP] = '{8'h00, 8'hFF, 8'h01, 8'h01, 8'h7F, 8'hAA, 8'h05, 8'h64, 8'h10, 8'hFF, 8'h80, 8'h9C};

  initial begin
    #10;
    check("R9", "reset hold", int'(hold), 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int f = 0; f < 16; f++) begin
      for (int i = 0; i < NP; i++) begin
        drive(4'(f), pa[i], pb[i], 1'((f + i) % 3 == 0));
      end
    end
    // carry boundary: 255 is not over, 256 is (R7)
    drive(4'd14, 8'd200, 8'd55, 1'b1);
    drive(4'd14, 8'd200, 8'd56, 1'b0);
    // zero test with varied B (R7)
    drive(4'd13, 8'd0, 8'hFF, 1'b1);
    drive(4'd13, 8'd1, 8'd0, 1'b0);
    drive(4'd0, 8'hFF, 8'hFF, 1'b0);
    while (sb_q.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule